// File: doc/BRIEF.md
# Configuration Channel Transaction Controller

This block is a small request engine that sits behind a register-bus slave port. It holds a bank of oscillator-frequency words, one per clock source, each loaded from its own reset value given as a parameter. Software cannot reach these words directly. It reaches them through a command channel: it places a value in the outgoing-data register, then writes a control word that names a device index and a function code and sets a start flag.

When the start flag is set, the engine checks the request and carries it out in the same clock edge that accepts the control write. A legal write copies the outgoing data into the selected oscillator word. A legal read copies the selected word into the return-data register. The status register reports completion and error, and every control write clears it first. A status or return-data read issued straight after the control write therefore already sees the result.

The bus port uses a valid/ready request channel and a valid/ready response channel, and allows one transfer at a time. Every accepted request, read or write, produces exactly one response. Write responses carry zero data. While a response is waiting with `rsp_ready` low, `req_ready` stays low, so no new request is taken. The response data holds steady until it is consumed. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The response appears on the next cycle.

Top module: `cfgchan_ctrl`

## Requirements
- R1: After reset, the register reads are: control (offset 0xA8) = 0x00100000, status (0xAC) = 0, outgoing data (0xA4) = 0, return data (0xA0) = 0. Each oscillator word holds its parameter reset value.
- R2: The outgoing-data register at offset 0xA4 is read/write and returns the last value written to it.
- R3: A write to the control register stores the written value with bits [19:12], [29:26] and 31 forced to zero. The stored fields are: device index in bits [11:0], function code in bits [25:20], write flag in bit 30.
- R4: Any write to the control register clears the status register. A control write with bit 31 clear leaves status at 0.
- R5: A control write with bit 31 set, function code 1 and device index below N_OSC, with bit 30 clear, sets status to 1 (bit 0 = done). It also loads the selected oscillator word into the return-data register.
- R6: A control write with bit 31 set, function code 1, device index below N_OSC and bit 30 set, copies the outgoing-data register into the selected oscillator word. Status becomes 1.
- R7: A started request with a function code other than 1, or with a device index of N_OSC or more, sets status to 3 (bit 1 = error, together with done). It leaves the return-data register and every oscillator word unchanged.
- R8: Writes to the return-data and status offsets have no effect. Reads of any offset other than 0xA0, 0xA4, 0xA8 and 0xAC return 0, and writes to those offsets have no effect.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` stays unchanged. A request presented during that time is not accepted.
- R10: The result of a started request is visible on the very next read of the status or return-data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed this cycle |
| rsp_rdata | output | 32 | Read data (0 for write responses) |

## Verification
A wrong oscillator word stays hidden until a legal read request names that device. After that read, the bad value shows in the return-data register within two transfers. A bad check on the function code or the device index shows in the status value on the very next status read, and a return-data read confirms whether the return register was wrongly overwritten. A fault in the response handshake shows within one cycle as a dropped, duplicated or changing response while `rsp_ready` is held low.

// File: rtl/cfgchan_pkg.sv
package cfgchan_pkg;
  localparam int unsigned DW = 32;

  localparam logic [11:0] OFF_RTN  = 12'h0A0;
  localparam logic [11:0] OFF_OUT  = 12'h0A4;
  localparam logic [11:0] OFF_CTRL = 12'h0A8;
  localparam logic [11:0] OFF_STAT = 12'h0AC;

  localparam int unsigned DEV_LSB = 0;
  localparam int unsigned DEV_W   = 12;
  localparam int unsigned FN_LSB  = 20;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned WR_BIT  = 30;
  localparam int unsigned GO_BIT  = 31;

  localparam logic [DW-1:0] CTRL_KEEP = 32'h43F0_0FFF;
  localparam logic [DW-1:0] CTRL_RST  = 32'h0010_0000;
  localparam logic [FN_W-1:0] FN_OSC  = 6'd1;

  typedef struct packed {
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic             wr;
    logic             go;
  } cmd_t;
endpackage

// File: rtl/cfgchan_cmd_decode.sv
module cfgchan_cmd_decode
  import cfgchan_pkg::*;
#(
  parameter int unsigned N_OSC = 4
) (
  input  logic [DW-1:0] word,
  output cmd_t          cmd,
  output logic          legal
);
  always_comb begin
    cmd.dev = word[DEV_LSB +: DEV_W];
    cmd.fn  = word[FN_LSB +: FN_W];
    cmd.wr  = word[WR_BIT];
    cmd.go  = word[GO_BIT];
    legal   = (cmd.fn == FN_OSC) && (cmd.dev < DEV_W'(N_OSC));
  end
endmodule

// File: rtl/cfgchan_osc_bank.sv
module cfgchan_osc_bank
  import cfgchan_pkg::*;
#(
  parameter int unsigned N_OSC = 4,
  parameter logic [DW-1:0] OSC_RESET [16] = '{default: 32'h0},
  localparam int unsigned IDX_W = (N_OSC > 1) ? $clog2(N_OSC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] word_q [N_OSC];

  for (genvar i = 0; i < N_OSC; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q[i] <= OSC_RESET[i];
      else if (wr_en && (idx == IDX_W'(i)))
        word_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_OSC; i++)
      if (idx == IDX_W'(i)) rd_data = word_q[i];
  end

  // R6: a write strobe lands its data in the addressed word on the next cycle
  a_r6_word_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data) || idx != $past(idx));
endmodule

// File: rtl/cfgchan_bus_port.sv
module cfgchan_bus_port
  import cfgchan_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] rd_value,
  output logic          accept,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r9_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  a_r9_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
endmodule

// File: rtl/cfgchan_ctrl.sv
module cfgchan_ctrl
  import cfgchan_pkg::*;
#(
  parameter int unsigned N_OSC  = 4,
  parameter int unsigned ADDR_W = 12,
  parameter logic [31:0] OSC_RESET [16] = '{0: 32'd50000000, 1: 32'd24576000,
                                            2: 32'd25000000, default: 32'd0},
  localparam int unsigned IDX_W = (N_OSC > 1) ? $clog2(N_OSC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata
);
  logic [DW-1:0] out_q, rtn_q, ctrl_q;
  logic [1:0]    stat_q;
  logic          accept, legal;
  logic          hit_rtn, hit_out, hit_ctrl, hit_stat;
  logic          ctrl_wr, go, osc_wr;
  logic [DW-1:0] rd_mux, osc_rd;
  cmd_t          cmd;

  assign hit_rtn  = req_addr == ADDR_W'(OFF_RTN);
  assign hit_out  = req_addr == ADDR_W'(OFF_OUT);
  assign hit_ctrl = req_addr == ADDR_W'(OFF_CTRL);
  assign hit_stat = req_addr == ADDR_W'(OFF_STAT);

  cfgchan_cmd_decode #(.N_OSC(N_OSC)) u_dec (
    .word (req_wdata),
    .cmd  (cmd),
    .legal(legal)
  );

  assign ctrl_wr = accept && req_write && hit_ctrl;
  assign go      = ctrl_wr && cmd.go;
  assign osc_wr  = go && legal && cmd.wr;

  cfgchan_osc_bank #(.N_OSC(N_OSC), .OSC_RESET(OSC_RESET)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (osc_wr),
    .idx    (cmd.dev[IDX_W-1:0]),
    .wr_data(out_q),
    .rd_data(osc_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      rtn_q  <= '0;
      ctrl_q <= CTRL_RST;
      stat_q <= 2'b00;
    end else begin
      if (accept && req_write && hit_out) out_q <= req_wdata;
      if (ctrl_wr) begin
        ctrl_q <= req_wdata & CTRL_KEEP;
        stat_q <= 2'b00;
        if (go) begin
          stat_q <= {!legal, 1'b1};
          if (legal && !cmd.wr) rtn_q <= osc_rd;
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (!req_write) begin
      if (hit_rtn)  rd_mux = rtn_q;
      if (hit_out)  rd_mux = out_q;
      if (hit_ctrl) rd_mux = ctrl_q;
      if (hit_stat) rd_mux = {30'd0, stat_q};
    end
  end

  cfgchan_bus_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rd_value (rd_mux),
    .accept   (accept),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );

  a_r4_stat_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && hit_ctrl && !req_wdata[GO_BIT]) |=> stat_q == 2'b00);
  a_r5_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && hit_ctrl && req_wdata[GO_BIT]) |=> stat_q[0]);
  a_r7_err_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[1] |-> stat_q[0]);
  a_r7_rtn_kept_on_bad_fn: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && hit_ctrl && req_wdata[GO_BIT] &&
     req_wdata[FN_LSB +: FN_W] != FN_OSC) |=> ($stable(rtn_q) && stat_q == 2'b11));
  a_r3_ctrl_go_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !ctrl_q[GO_BIT]);
endmodule

// File: tb/cfgchan_ctrl_bench.sv
module cfgchan_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam logic [31:0] RV0 = 32'h0123_4567;
  localparam logic [31:0] RV1 = 32'h89AB_CDEF;
  localparam logic [31:0] RV2 = 32'h0BAD_F00D;
  localparam logic [31:0] RST_VALS [16] = '{0: RV0, 1: RV1, 2: RV2, default: 32'h0};

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgchan_ctrl #(.N_OSC(N), .ADDR_W(12), .OSC_RESET(RST_VALS)) u_cfgchan_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic xfer(input bit w, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] q);
    @(negedge clk);
    rsp_ready = 1; req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 0;
    q = rsp_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] q;
    xfer(1, a, d, q);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] q);
    xfer(0, a, 32'h0, q);
  endtask

  task automatic t_reset;
    logic [31:0] q;
    rd(12'h0A0, q); chk("R1 rtn", q, 0);
    rd(12'h0A4, q); chk("R1 out", q, 0);
    rd(12'h0A8, q); chk("R1 ctrl", q, 32'h0010_0000);
    rd(12'h0AC, q); chk("R1 stat", q, 0);
  endtask

  task automatic t_outdata;
    logic [31:0] q;
    wr(12'h0A4, 32'hDEAD_BEEF); rd(12'h0A4, q); chk("R2 out rw", q, 32'hDEAD_BEEF);
    wr(12'h0A4, 32'h1357_9BDF); rd(12'h0A4, q); chk("R2 out rw2", q, 32'h1357_9BDF);
  endtask

  task automatic t_legal_read;
    logic [31:0] q;
    logic [31:0] exp [3] = '{RV0, RV1, RV2};
    for (int d = 0; d < N; d++) begin
      wr(12'h0A8, 32'h8010_0000 | d);
      rd(12'h0AC, q); chk("R5 R10 stat done", q, 1);
      rd(12'h0A0, q); chk("R1 R5 rtn reset value", q, exp[d]);
    end
  endtask

  task automatic t_ctrl_mask;
    logic [31:0] q;
    wr(12'h0A8, 32'hFFFF_FFFF);
    rd(12'h0A8, q); chk("R3 ctrl masked", q, 32'h43F0_0FFF);
    rd(12'h0AC, q); chk("R7 dev out of range", q, 3);
    wr(12'h0A8, 32'h0010_0000);
    rd(12'h0AC, q); chk("R4 stat cleared", q, 0);
  endtask

  task automatic t_legal_write;
    logic [31:0] q;
    wr(12'h0A4, 32'hCAFE_0001);
    wr(12'h0A8, 32'hC010_0001);
    rd(12'h0AC, q); chk("R6 write done", q, 1);
    wr(12'h0A8, 32'h8010_0001);
    rd(12'h0A0, q); chk("R6 word updated", q, 32'hCAFE_0001);
    wr(12'h0A8, 32'h8010_0002);
    rd(12'h0A0, q); chk("R6 neighbour kept", q, RV2);
  endtask

  task automatic t_illegal;
    logic [31:0] q;
    wr(12'h0A8, 32'h8010_0000);
    wr(12'h0A8, 32'h8020_0001);
    rd(12'h0AC, q); chk("R7 bad fn stat", q, 3);
    rd(12'h0A0, q); chk("R7 rtn kept", q, RV0);
    wr(12'h0A8, 32'h8010_0003);
    rd(12'h0AC, q); chk("R7 dev==N stat", q, 3);
    wr(12'h0A4, 32'h5555_AAAA);
    wr(12'h0A8, 32'hC020_0000);
    wr(12'h0A8, 32'hC010_0003);
    wr(12'h0A8, 32'h8010_0000);
    rd(12'h0A0, q); chk("R7 word0 untouched", q, RV0);
  endtask

  task automatic t_ignored;
    logic [31:0] q;
    wr(12'h0A0, 32'h1234_5678);
    rd(12'h0A0, q); chk("R8 rtn write ignored", q, RV0);
    wr(12'h0AC, 32'hFFFF_FFFF);
    rd(12'h0AC, q); chk("R8 stat write ignored", q, 1);
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, q); chk("R8 unknown reads zero", q, 0);
    rd(12'h0A4, q); chk("R8 out unaffected", q, 32'h5555_AAAA);
  endtask

  task automatic t_backpressure;
    logic [31:0] q, held;
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 12'h0A4;
    @(posedge clk); #1;
    req_valid = 0;
    held = rsp_rdata;
    chk("R9 first rsp data", held, 32'h5555_AAAA);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 12'h0A4; req_wdata = 32'h0;
    chk("R9 ready low", {31'd0, req_ready}, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R9 rsp held valid", {31'd0, rsp_valid}, 1);
    chk("R9 rsp data stable", rsp_rdata, held);
    @(negedge clk);
    req_valid = 0; rsp_ready = 1;
    @(posedge clk); #1;
    rd(12'h0A4, q); chk("R9 blocked write not taken", q, 32'h5555_AAAA);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_reset();
        t_outdata();
        t_legal_read();
        t_ctrl_mask();
        t_legal_write();
        t_illegal();
        t_ignored();
        t_backpressure();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule